// File: doc/BRIEF.md
# Bounded Rational Approximation Engine

This block finds the best fraction p/q that approximates a target ratio a/b, where p and q must each fit under a cap of their own. The caps are the largest values a fractional clock divider's numerator and denominator fields can hold. The engine works through the continued-fraction expansion of a/b one term at a time and builds up the convergents. When the next convergent would break a cap, it returns the last convergent that fitted.

To run it, present the target numerator and denominator and the two caps, then pulse `start` while the engine is idle. The engine captures all four values, raises `busy`, and steps through the expansion. Each term's quotient and remainder come from an internal shift-subtract divider that needs one clock per bit. At the end the engine loads the result pair, drops `busy`, and raises `done` for a single cycle. The result then stays put until the next accepted start.

Top module: `rat_approx_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `res_num` and `res_den` are 0.
- R2: `start` is accepted only while `busy` is 0. A start pulse that arrives while `busy` is 1 changes neither the captured operands nor the result of the run in progress.
- R3: If the target denominator is zero and both caps are at least 1, the result is 1/0. No division is performed.
- R4: The engine begins with remainder pair (a, b), previous convergent 0/1 and current convergent 1/0. Each term computes quotient f = x div y and moves the remainder pair from (x, y) to (y, x mod y). The new current convergent is previous + f·current, computed separately for numerator and denominator and wrapped to W bits. The old current convergent becomes the previous one.
- R5: A term is computed only while the remainder denominator is nonzero, the current numerator is below its cap, and the current denominator is below its cap. If, after the last term, either current value is strictly above its cap, the previous convergent is the result.
- R6: A current convergent whose numerator or denominator equals its cap exactly stops the expansion and is returned as the result. It does not trigger the fallback.
- R7: `done` is high for exactly one cycle, and `busy` is 0 in that cycle. While the engine is idle and `start` is 0, `res_num` and `res_den` do not change.
- R8: The internal divider returns a quotient and remainder with quotient·divisor + remainder = dividend and remainder < divisor. With k terms computed, `done` rises k·(W+2)+1 rising clock edges after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (only honoured while idle) |
| num_in | input | W | Target ratio numerator |
| den_in | input | W | Target ratio denominator |
| num_max | input | W | Cap on the result numerator |
| den_max | input | W | Cap on the result denominator |
| busy | output | 1 | High from the accepting edge until the result is loaded |
| done | output | 1 | One-cycle pulse when the result is valid |
| res_num | output | W | Chosen numerator |
| res_den | output | W | Chosen denominator |

## Verification
The bench goes after the corner cases of the cap tests. In one case a convergent lands exactly on a cap: a strict-versus-inclusive mistake there would wrongly fall back to the previous convergent. In another the very first term already breaks the cap: a design that misses this would return an oversized numerator instead of 1/0. A zero target numerator and a zero target denominator are both exercised. A design that started a division on a zero denominator would hang or take too long, and the latency check would catch it. A target near 2^63 checks that the divider handles the top bit correctly. A start pulse injected mid-run makes sure a design that reloads its operands while busy returns the wrong pair.

// File: rtl/rat_pkg.sv
// Package: shared state encoding for the rational approximation engine.
// Assumes: nothing beyond standard SystemVerilog.
package rat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // waiting for start
        ST_CHECK = 2'd1,   // evaluate loop condition
        ST_DIV   = 2'd2    // divider running for one term
    } eng_state_t;
endpackage

// File: rtl/rat_div.sv
// Module: restoring shift-subtract divider, one quotient bit per clock.
// Assumes: divisor is nonzero when start is pulsed; start is not pulsed
// while a division is in progress. done is high for one cycle, W+1 cycles
// after start, and quo/rem hold until the next start.
module rat_div #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         done,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic          running;
    logic [CW-1:0] cnt;
    logic [W-1:0]  acc;
    logic [W-1:0]  dq;
    logic [W-1:0]  dvs;
    logic [W-1:0]  dvd_keep;
    logic [W:0]    trial;
    logic [W:0]    diff;
    logic          fits;

    // Trial subtraction for the current bit.
    always_comb begin
        trial = {acc, dq[W-1]};
        diff  = trial - {1'b0, dvs};
        fits  = ~diff[W];
    end

    // Load operands on start, then shift one bit per cycle until the count is spent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running  <= 1'b0;
            cnt      <= '0;
            acc      <= '0;
            dq       <= '0;
            dvs      <= '0;
            dvd_keep <= '0;
        end else if (start) begin
            running  <= 1'b1;
            cnt      <= CW'(W);
            acc      <= '0;
            dq       <= dividend;
            dvs      <= divisor;
            dvd_keep <= dividend;
        end else if (running) begin
            if (cnt != '0) begin
                acc <= fits ? diff[W-1:0] : trial[W-1:0];
                dq  <= {dq[W-2:0], fits};
                cnt <= cnt - 1'b1;
            end else begin
                running <= 1'b0;
            end
        end
    end

    assign done = running && (cnt == '0);
    assign quo  = dq;
    assign rem  = acc;

    // R8: division identity and remainder bound when the result is presented.
    a_r8_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((quo * dvs + rem) == dvd_keep) && (rem < dvs));
endmodule

// File: rtl/rat_conv_step.sv
// Module: one convergent update, next = prev + quot * cur, wrapped to W bits.
// Assumes: purely combinational; caller registers the result.
module rat_conv_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] prev,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] quot,
    output logic [W-1:0] nxt
);
    // Multiply-accumulate for a single convergent component.
    always_comb nxt = prev + quot * cur;
endmodule

// File: rtl/rat_approx_engine.sv
// Module: sequential best-rational-approximation engine under separate caps.
// Assumes: start is a level sampled each clock and honoured only when idle;
// operands and caps are captured at the accepting edge.
module rat_approx_engine #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] num_in,
    input  logic [W-1:0] den_in,
    input  logic [W-1:0] num_max,
    input  logic [W-1:0] den_max,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] res_num,
    output logic [W-1:0] res_den
);
    import rat_pkg::*;

    localparam int NCOMP = 2;   // numerator and denominator lanes

    eng_state_t   state;
    logic [W-1:0] x_rem, y_rem;
    logic [W-1:0] n_prev, n_cur, d_prev, d_cur;
    logic [W-1:0] lim_n, lim_d;
    logic         done_q;
    logic         keep_going;
    logic         over_cap;
    logic         div_start, div_done;
    logic [W-1:0] div_quo, div_rem;
    logic [W-1:0] cv_prev [NCOMP];
    logic [W-1:0] cv_cur  [NCOMP];
    logic [W-1:0] cv_next [NCOMP];

    // Loop condition and cap test on the current convergent.
    always_comb begin
        keep_going = (y_rem != '0) && (n_cur < lim_n) && (d_cur < lim_d);
        over_cap   = (n_cur > lim_n) || (d_cur > lim_d);
        div_start  = (state == ST_CHECK) && keep_going;
    end

    // Gather convergent lanes for the update units.
    always_comb begin
        cv_prev[0] = n_prev;  cv_cur[0] = n_cur;
        cv_prev[1] = d_prev;  cv_cur[1] = d_cur;
    end

    for (genvar g = 0; g < NCOMP; g++) begin : g_lane
        rat_conv_step #(.W(W)) u_step (
            .prev (cv_prev[g]),
            .cur  (cv_cur[g]),
            .quot (div_quo),
            .nxt  (cv_next[g])
        );
    end

    rat_div #(.W(W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (x_rem),
        .divisor  (y_rem),
        .done     (div_done),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    // Control sequence: capture, test, divide, update, and publish the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            x_rem   <= '0;
            y_rem   <= '0;
            n_prev  <= '0;
            n_cur   <= '0;
            d_prev  <= '0;
            d_cur   <= '0;
            lim_n   <= '0;
            lim_d   <= '0;
            res_num <= '0;
            res_den <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        x_rem  <= num_in;
                        y_rem  <= den_in;
                        lim_n  <= num_max;
                        lim_d  <= den_max;
                        n_prev <= '0;
                        d_prev <= W'(1);
                        n_cur  <= W'(1);
                        d_cur  <= '0;
                        state  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (keep_going) begin
                        state <= ST_DIV;
                    end else begin
                        res_num <= over_cap ? n_prev : n_cur;
                        res_den <= over_cap ? d_prev : d_cur;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_DIV: begin
                    if (div_done) begin
                        x_rem  <= y_rem;
                        y_rem  <= div_rem;
                        n_prev <= n_cur;
                        n_cur  <= cv_next[0];
                        d_prev <= d_cur;
                        d_cur  <= cv_next[1];
                        state  <= ST_CHECK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy = (state != ST_IDLE);
    assign done = done_q;

    // R7: done is a single-cycle pulse while not busy.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R7: result holds while idle with no start.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(res_num) && $stable(res_den)));
    // R2: a start while busy leaves the captured caps and operands alone.
    a_r2_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(lim_n) && $stable(lim_d)));
    // R5: the published pair never exceeds its caps.
    a_r5_within_caps: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((res_num <= lim_n) && (res_den <= lim_d)));
    // R3: no division is launched with a zero remainder denominator.
    a_r3_no_zero_div: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DIV) |-> (y_rem != '0));
endmodule

// File: tb/tb_rat_approx_engine.sv
module tb_rat_approx_engine;
    localparam int W = 64;
    localparam logic [W-1:0] ONES = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] n, d, nm, dm, en, ed;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{64'd3,      64'd1,      64'd100,   64'd100,   64'd3,    64'd1},
        '{64'd355,    64'd113,    64'd1000,  64'd1000,  64'd355,  64'd113},
        '{64'd355,    64'd113,    64'd100,   64'd100,   64'd22,   64'd7},
        '{64'd314159, 64'd100000, 64'd65535, 64'd65535, 64'd9563, 64'd3044},
        '{64'd0,      64'd7,      64'd10,    64'd10,    64'd0,    64'd1},
        '{64'd3,      64'd1,      64'd2,     64'd100,   64'd1,    64'd0},
        '{64'd3,      64'd1,      64'd3,     64'd100,   64'd3,    64'd1},
        '{64'd1,      64'd3,      64'd100,   64'd100,   64'd1,    64'd3},
        '{64'd1,      64'd3,      64'd100,   64'd2,     64'd0,    64'd1},
        '{64'd22,     64'd7,      64'd3,     64'd100,   64'd3,    64'd1},
        '{64'h8000_0000_0000_0000, 64'd1, ONES, ONES, 64'h8000_0000_0000_0000, 64'd1},
        '{64'd5,      64'd0,      64'd10,    64'd10,    64'd1,    64'd0}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] num_in = '0, den_in = '0, num_max = '0, den_max = '0;
    logic         busy, done;
    logic [W-1:0] res_num, res_den;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;   // 50 MHz

    rat_approx_engine #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .num_in(num_in), .den_in(den_in), .num_max(num_max), .den_max(den_max),
        .busy(busy), .done(done), .res_num(res_num), .res_den(res_den)
    );

    task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Term count from the requirement-level loop (R4/R5 rules).
    function automatic int terms(input logic [W-1:0] a, b, nm, dm);
        logic [W-1:0] x, y, np, nc, dp, dc, f, t;
        int k;
        x = a; y = b; np = 0; dp = 1; nc = 1; dc = 0; k = 0;
        while (y != 0 && nc < nm && dc < dm) begin
            f = x / y; t = y; y = x % y; x = t;
            t = np + f * nc; np = nc; nc = t;
            t = dp + f * dc; dp = dc; dc = t;
            k++;
        end
        return k;
    endfunction

    // Launch a run at a negedge; returns edges from the accepting edge until done.
    task automatic run(input logic [W-1:0] a, b, nm, dm, output int lat, output bit busy_ok);
        @(negedge clk);
        num_in = a; den_in = b; num_max = nm; den_max = dm; start = 1'b1;
        @(posedge clk);
        lat = 0; busy_ok = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && lat < 5000) begin
            if (!busy) busy_ok = 1'b0;
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        bit bok;
        logic [W-1:0] hn, hd;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1 busy/done after reset", W'({busy, done}), 0);
        chk(res_num == 0 && res_den == 0, "R1 result after reset", res_num | res_den, 0);
        rst_n = 1'b1;

        // Vector walk (R4, R5, R6, R3, R8)
        for (int i = 0; i < NV; i++) begin
            run(VEC[i].n, VEC[i].d, VEC[i].nm, VEC[i].dm, lat, bok);
            chk(res_num == VEC[i].en, $sformatf("R4 R5 R6 vec %0d numerator", i), res_num, VEC[i].en);
            chk(res_den == VEC[i].ed, $sformatf("R4 R5 R6 vec %0d denominator", i), res_den, VEC[i].ed);
            chk(lat == terms(VEC[i].n, VEC[i].d, VEC[i].nm, VEC[i].dm) * (W + 2) + 1,
                $sformatf("R8 vec %0d latency", i), W'(lat),
                W'(terms(VEC[i].n, VEC[i].d, VEC[i].nm, VEC[i].dm) * (W + 2) + 1));
            chk(bok, $sformatf("R8 vec %0d busy throughout", i), W'(bok), 1);
            chk(!busy, $sformatf("R7 vec %0d busy low with done", i), W'(busy), 0);
            @(negedge clk);
            chk(!done, $sformatf("R7 vec %0d done single cycle", i), W'(done), 0);
        end

        // R3: zero denominator gives 1/0 on the very next edge
        run(64'd99, 64'd0, 64'd50, 64'd50, lat, bok);
        chk(res_num == 1 && res_den == 0, "R3 zero denominator result", res_num, 1);
        chk(lat == 1, "R3 no divide latency", W'(lat), 1);

        // R7: result holds while idle, inputs changing, no start
        hn = res_num; hd = res_den;
        @(negedge clk);
        num_in = 64'd7; den_in = 64'd2; num_max = 64'd9; den_max = 64'd9;
        repeat (6) @(negedge clk);
        chk(res_num == hn && res_den == hd, "R7 hold while idle", res_num, hn);

        // R2: start during busy is ignored
        @(negedge clk);
        num_in = 64'd355; den_in = 64'd113; num_max = 64'd1000; den_max = 64'd1000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        num_in = 64'd5; den_in = 64'd0; num_max = 64'd3; den_max = 64'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        chk(res_num == 355 && res_den == 113, "R2 start while busy ignored", res_num, 355);

        // R6: numerator cap reached exactly on 22/7 keeps 22/7
        run(64'd355, 64'd113, 64'd22, 64'd1000, lat, bok);
        chk(res_num == 22 && res_den == 7, "R6 exact cap kept", res_num, 22);
        // R5: one below the cap falls back
        run(64'd355, 64'd113, 64'd21, 64'd1000, lat, bok);
        chk(res_num == 3 && res_den == 1, "R5 fallback to previous", res_num, 3);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule